// File: doc/BRIEF.md
# BCD Calendar Clock with Freezable Register View

This block keeps the time of day and the calendar in packed BCD. It counts hundredths of a second, seconds, minutes, hours, day of week, date of month, month and year. A one-cycle enable that arrives at 100 Hz advances it. Two banks hold the time. The running bank keeps counting on every tick. The visible bank is what the register bus reads and writes, and it is refreshed from the running bank on each tick.

Software can clear the transfer-enable bit in the control register. This holds the visible bank steady so that a multi-byte read or update stays consistent, and the running bank keeps counting meanwhile. Writes made while the visible bank is held are applied to the running bank on the first tick after transfer is enabled again. Only the written registers are replaced. Writes made while transfer is enabled are applied to both banks at once.

The register bus is synchronous. Writes take effect on the clock edge that samples `we_i`, and read data is combinational from the address. A one-cycle strobe marks each rollover of the hundredths count, for use by alarm logic that sits outside this block.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset these registers read 00h: 00h (hundredths), 01h (seconds), 02h (minutes), 04h (hours) and 0Ah (year). Register 06h (day), 08h (date) and 09h (month) each read 01h. Control register 0Bh reads 80h and the strobe output is low.
- R2: Undefined bits read 0 whatever is written. The readable masks are: 00h FFh, 01h 7Fh, 02h 7Fh, 04h 7Fh, 06h 07h, 08h 3Fh, 09h 9Fh, 0Ah FFh, 0Bh 80h. Addresses 03h, 05h, 07h and 0Ch–3Fh read 00h, and writes to them have no effect.
- R3: Each tick adds one BCD step to the hundredths count, and the change is visible on the next read. The seconds and the higher fields change only on the tick that takes the hundredths count from 99 to 00.
- R4: Seconds and minutes wrap from 59 to 00 and carry. In 24-hour mode (04h bit 6 = 0), hours run 00–23, and 23→00 carries into the day. The day of week wraps from 7 to 1.
- R5: In 12-hour mode (04h bit 6 = 1), bit 5 is PM and bits 4:0 are the BCD hour. The hour sequence is 12, 01 … 11. PM toggles on the step from 11 to 12, and the day advances only on 11 PM → 12 AM.
- R6: A date carries into the month after the last day of that month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R7: While month bit 7 is 1, the oscillator is stopped: the running bank does not advance and the visible bank is not refreshed.
- R8: While control bit 7 (transfer enable) is 0, the visible bank holds still. The running bank keeps counting, and the first tick after the bit returns to 1 shows the up-to-date time.
- R9: A write to a time register while transfer is enabled updates both banks at once.
- R10: A write to a time register while transfer is disabled changes only the visible bank. On the first tick after transfer is enabled again, that register is copied into the running bank, and unwritten registers keep their advanced values.
- R11: The strobe output is high for exactly one cycle. It rises in the cycle after the clock edge on which the hundredths count went from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 100 Hz advance enable, one cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (6) | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| roll_o | output | 1 | Hundredths rollover strobe |

## Verification
The assertions check several rules on every cycle:
- a held visible bank does not move without a bus write;
- a stopped oscillator freezes the running bank;
- a direct seconds write lands in the running bank on the next edge;
- unused addresses read zero;
- seconds change only together with a rollover strobe;
- the strobe never lasts two cycles.

Only the bench scenarios can show the calendar arithmetic: month lengths, leap years, the 12-hour sequence with its PM toggle, and the carry chain from hundredths up to the year. The same holds for the deferred copy of frozen writes, where advanced and written fields mix on the commit tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_TIME  = 11;
    localparam int CTRL_ADDR = 11;
    localparam int A_CS      = 0;
    localparam int A_SEC     = 1;
    localparam int A_MIN     = 2;
    localparam int A_HOUR    = 4;
    localparam int A_DOW     = 6;
    localparam int A_DATE    = 8;
    localparam int A_MON     = 9;
    localparam int A_YEAR    = 10;

    typedef logic [NUM_TIME-1:0][BYTE_W-1:0] tbank_t;

    // readable bits of each time slot; zero marks an unused address
    function automatic logic [BYTE_W-1:0] field_mask(input int unsigned a);
        case (a)
            A_CS, A_YEAR:         return 8'hFF;
            A_SEC, A_MIN, A_HOUR: return 8'h7F;
            A_DOW:                return 8'h07;
            A_DATE:               return 8'h3F;
            A_MON:                return 8'h9F;
            default:              return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    function automatic tbank_t bank_reset();
        tbank_t b;
        b = '0;
        b[A_DOW]  = 8'h01;
        b[A_DATE] = 8'h01;
        b[A_MON]  = 8'h01;
        return b;
    endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [4:0] month_i,
    input  logic [4:0] year_lo_i,
    output logic [5:0] last_o
);
    logic leap;

    always_comb begin
        // BCD year divisible by 4: even tens needs units 0/4/8, odd tens needs 2/6
        if (year_lo_i[4])
            leap = (year_lo_i[3:0] == 4'd2) || (year_lo_i[3:0] == 4'd6);
        else
            leap = (year_lo_i[3:0] == 4'd0) || (year_lo_i[3:0] == 4'd4) ||
                   (year_lo_i[3:0] == 4'd8);
        case (month_i)
            5'h02:                      last_o = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
            default:                    last_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  tbank_t cur_i,
    input  logic   step_i,
    output tbank_t nxt_o,
    output logic   wrap_o
);
    logic [5:0] last_day;
    logic       c;
    logic       pm;
    logic [4:0] h12;
    logic [5:0] h24;
    logic [5:0] dt;
    logic [4:0] mo;

    cal_month_len u_len (
        .month_i   (cur_i[A_MON][4:0]),
        .year_lo_i (cur_i[A_YEAR][4:0]),
        .last_o    (last_day)
    );

    always_comb begin
        nxt_o  = cur_i;
        wrap_o = 1'b0;
        c      = 1'b0;
        pm     = cur_i[A_HOUR][5];
        h12    = cur_i[A_HOUR][4:0];
        h24    = cur_i[A_HOUR][5:0];
        dt     = cur_i[A_DATE][5:0];
        mo     = cur_i[A_MON][4:0];
        if (step_i) begin
            if (cur_i[A_CS] == 8'h99) begin
                nxt_o[A_CS] = 8'h00;
                wrap_o      = 1'b1;
                c           = 1'b1;
            end else begin
                nxt_o[A_CS] = bcd_inc(cur_i[A_CS]);
            end
        end
        if (c) begin
            if (cur_i[A_SEC][6:0] == 7'h59) nxt_o[A_SEC] = 8'h00;
            else begin nxt_o[A_SEC] = bcd_inc(cur_i[A_SEC]); c = 1'b0; end
        end
        if (c) begin
            if (cur_i[A_MIN][6:0] == 7'h59) nxt_o[A_MIN] = 8'h00;
            else begin nxt_o[A_MIN] = bcd_inc(cur_i[A_MIN]); c = 1'b0; end
        end
        if (c) begin
            if (cur_i[A_HOUR][6]) begin
                if (h12 == 5'h12) begin
                    h12 = 5'h01;
                    c   = 1'b0;
                end else if (h12 == 5'h11) begin
                    h12 = 5'h12;
                    c   = pm;
                    pm  = ~pm;
                end else begin
                    h12 = (h12[3:0] == 4'd9) ? 5'h10 : h12 + 5'd1;
                    c   = 1'b0;
                end
                nxt_o[A_HOUR] = {2'b01, pm, h12};
            end else begin
                if (h24 == 6'h23) h24 = 6'h00;
                else begin
                    h24 = (h24[3:0] == 4'd9) ? {h24[5:4] + 2'd1, 4'd0} : h24 + 6'd1;
                    c   = 1'b0;
                end
                nxt_o[A_HOUR] = {2'b00, h24};
            end
        end
        if (c) begin
            nxt_o[A_DOW] = (cur_i[A_DOW][2:0] == 3'd7) ? 8'h01 : cur_i[A_DOW] + 8'd1;
            if (dt >= last_day) dt = 6'h01;
            else begin
                dt = (dt[3:0] == 4'd9) ? {dt[5:4] + 2'd1, 4'd0} : dt + 6'd1;
                c  = 1'b0;
            end
            nxt_o[A_DATE] = {2'b00, dt};
        end
        if (c) begin
            if (mo == 5'h12) mo = 5'h01;
            else begin
                mo = (mo[3:0] == 4'd9) ? 5'h10 : mo + 5'd1;
                c  = 1'b0;
            end
            nxt_o[A_MON] = {cur_i[A_MON][7:5], mo};
        end
        if (c) begin
            nxt_o[A_YEAR] = (cur_i[A_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur_i[A_YEAR]);
        end
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              roll_o
);
    typedef struct packed {
        tbank_t              vis;
        tbank_t              cur;
        logic [NUM_TIME-1:0] dirty;
        logic                te;
        logic                roll;
    } state_t;

    state_t st_d, st_q;
    tbank_t adv_bank;
    logic   adv_wrap;
    logic   running;
    logic   commit;
    logic [7:0] wval;

    assign running = ~st_q.cur[A_MON][7];
    assign commit  = tick_i & st_q.te & (|st_q.dirty);

    cal_advance u_adv (
        .cur_i  (st_q.cur),
        .step_i (tick_i & running),
        .nxt_o  (adv_bank),
        .wrap_o (adv_wrap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cur  = adv_bank;
        st_d.roll = adv_wrap;
        wval      = 8'h00;
        if (commit) begin
            for (int i = 0; i < NUM_TIME; i++)
                if (st_q.dirty[i]) st_d.cur[i] = st_q.vis[i];
            st_d.dirty = '0;
        end
        if (tick_i && st_q.te && (running || commit))
            st_d.vis = st_d.cur;
        if (we_i) begin
            if (addr_i == ADDR_W'(CTRL_ADDR))
                st_d.te = wdata_i[7];
            for (int i = 0; i < NUM_TIME; i++) begin
                if (addr_i == ADDR_W'(i) && field_mask(i) != 8'h00) begin
                    wval        = wdata_i & field_mask(i);
                    st_d.vis[i] = wval;
                    if (st_q.te) begin
                        st_d.cur[i]   = wval;
                        st_d.dirty[i] = 1'b0;
                    end else begin
                        st_d.dirty[i] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vis   <= bank_reset();
            st_q.cur   <= bank_reset();
            st_q.dirty <= '0;
            st_q.te    <= 1'b1;
            st_q.roll  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (addr_i == ADDR_W'(CTRL_ADDR))
            rdata_o = {st_q.te, 7'b0};
        for (int i = 0; i < NUM_TIME; i++)
            if (addr_i == ADDR_W'(i)) rdata_o = st_q.vis[i];
    end

    assign roll_o = st_q.roll;
endmodule

// File: rtl/cal_clock_checks.sv
module cal_clock_checks
    import cal_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                we_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [7:0]          wdata_i,
    input logic [7:0]          rdata_o,
    input logic                roll_o,
    input logic                te,
    input tbank_t              vis,
    input tbank_t              cur,
    input logic [NUM_TIME-1:0] dirty
);
    AST_ROLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_o && cur[A_CS] == 8'h00) |=> !roll_o); // R11

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!te && !we_i) |=> $stable(vis)); // R8

    AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[A_MON][7] && !we_i && dirty == '0) |=> $stable(cur)); // R7

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && te && addr_i == ADDR_W'(A_SEC)) |=> cur[A_SEC] == ($past(wdata_i) & 8'h7F)); // R9

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(3) || addr_i == ADDR_W'(5) || addr_i == ADDR_W'(7) ||
         addr_i >= ADDR_W'(12)) |-> rdata_o == 8'h00); // R2

    AST_SEC_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(we_i) && $past(dirty) == '0 && cur[A_SEC] != $past(cur[A_SEC])) |-> roll_o); // R3
endmodule

bind bcd_calendar_clock cal_clock_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .roll_o  (roll_o),
    .te      (st_q.te),
    .vis     (st_q.vis),
    .cur     (st_q.cur),
    .dirty   (st_q.dirty)
);

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [5:0] addr = 6'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       roll;

    typedef struct {
        string      tag;
        bit         is_roll;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar_clock u_bcd_calendar_clock (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .roll_o(roll)
    );

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic exp_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk); addr = a;
        it.tag = tag; it.is_roll = 1'b0; it.exp = e;
        q.push_back(it);
        #1 -> chk_ev;
    endtask

    task automatic exp_roll(input logic e, input string tag);
        item_t it;
        it.tag = tag; it.is_roll = 1'b1; it.exp = {7'b0, e};
        q.push_back(it);
        #1 -> chk_ev;
    endtask

    task automatic end_of_hour();
        wr(6'h00, 8'h99); wr(6'h01, 8'h59); wr(6'h02, 8'h59);
    endtask

    task automatic end_of_day();
        end_of_hour(); wr(6'h04, 8'h23);
    endtask

    initial begin : monitor
        item_t it;
        logic [7:0] act;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                it = q.pop_front();
                act = it.is_roll ? {7'b0, roll} : rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        exp_rd(6'h00, 8'h00, "R1 hundredths"); exp_rd(6'h01, 8'h00, "R1 seconds");
        exp_rd(6'h04, 8'h00, "R1 hours");      exp_rd(6'h06, 8'h01, "R1 day");
        exp_rd(6'h08, 8'h01, "R1 date");       exp_rd(6'h09, 8'h01, "R1 month");
        exp_rd(6'h0A, 8'h00, "R1 year");       exp_rd(6'h0B, 8'h80, "R1 control");
        exp_roll(1'b0, "R1 strobe");
        // R3 hundredths step
        tk(5);
        exp_rd(6'h00, 8'h05, "R3 five ticks"); exp_rd(6'h01, 8'h00, "R3 seconds held");
        // R9 direct load, full carry chain R4 R6 R11
        wr(6'h00, 8'h98); wr(6'h01, 8'h59); wr(6'h02, 8'h59); wr(6'h04, 8'h23);
        wr(6'h06, 8'h07); wr(6'h08, 8'h31); wr(6'h09, 8'h12); wr(6'h0A, 8'h99);
        exp_rd(6'h00, 8'h98, "R9 hundredths loaded"); exp_rd(6'h08, 8'h31, "R9 date loaded");
        tk(1); exp_roll(1'b0, "R11 no strobe at 98->99");
        exp_rd(6'h00, 8'h99, "R3 at 99");
        tk(1); exp_roll(1'b1, "R11 strobe at 99->00");
        exp_rd(6'h00, 8'h00, "R3 wrap"); exp_rd(6'h01, 8'h00, "R4 seconds wrap");
        exp_rd(6'h02, 8'h00, "R4 minutes wrap"); exp_rd(6'h04, 8'h00, "R4 hours 23->00");
        exp_rd(6'h06, 8'h01, "R4 day 7->1"); exp_rd(6'h08, 8'h01, "R6 date 31->01");
        exp_rd(6'h09, 8'h01, "R6 month 12->01"); exp_rd(6'h0A, 8'h00, "R6 year 99->00");
        tk(1); exp_roll(1'b0, "R11 strobe one cycle");
        // R2 masks and unused addresses
        wr(6'h01, 8'hFF); exp_rd(6'h01, 8'h7F, "R2 seconds mask");
        wr(6'h06, 8'hFF); exp_rd(6'h06, 8'h07, "R2 day mask");
        wr(6'h08, 8'hFF); exp_rd(6'h08, 8'h3F, "R2 date mask");
        wr(6'h04, 8'hFF); exp_rd(6'h04, 8'h7F, "R2 hours mask");
        wr(6'h03, 8'h55); exp_rd(6'h03, 8'h00, "R2 unused 03");
        wr(6'h20, 8'h5A); exp_rd(6'h20, 8'h00, "R2 unused 20");
        wr(6'h0B, 8'hFF); exp_rd(6'h0B, 8'h80, "R2 control mask");
        // R6 month lengths and leap years
        wr(6'h0A, 8'h24); wr(6'h09, 8'h02); wr(6'h08, 8'h28); end_of_day(); tk(1);
        exp_rd(6'h08, 8'h29, "R6 leap Feb 29"); exp_rd(6'h09, 8'h02, "R6 still Feb");
        end_of_day(); tk(1);
        exp_rd(6'h08, 8'h01, "R6 leap Feb end"); exp_rd(6'h09, 8'h03, "R6 March");
        wr(6'h0A, 8'h23); wr(6'h09, 8'h02); wr(6'h08, 8'h28); end_of_day(); tk(1);
        exp_rd(6'h08, 8'h01, "R6 common Feb end"); exp_rd(6'h09, 8'h03, "R6 March common");
        wr(6'h0A, 8'h12); wr(6'h09, 8'h02); wr(6'h08, 8'h28); end_of_day(); tk(1);
        exp_rd(6'h08, 8'h29, "R6 leap odd tens");
        wr(6'h09, 8'h04); wr(6'h08, 8'h30); end_of_day(); tk(1);
        exp_rd(6'h08, 8'h01, "R6 April end"); exp_rd(6'h09, 8'h05, "R6 May");
        // R5 12-hour mode
        wr(6'h08, 8'h10); wr(6'h09, 8'h05);
        wr(6'h04, 8'h51); end_of_hour(); tk(1);
        exp_rd(6'h04, 8'h72, "R5 11AM->12PM"); exp_rd(6'h08, 8'h10, "R5 no day at noon");
        end_of_hour(); tk(1);
        exp_rd(6'h04, 8'h61, "R5 12PM->01PM");
        wr(6'h04, 8'h71); end_of_hour(); tk(1);
        exp_rd(6'h04, 8'h52, "R5 11PM->12AM"); exp_rd(6'h08, 8'h11, "R5 day at midnight");
        // R7 oscillator stop
        wr(6'h00, 8'h10); wr(6'h09, 8'h85); tk(3);
        exp_rd(6'h00, 8'h10, "R7 stopped"); exp_rd(6'h09, 8'h85, "R7 month bit7");
        wr(6'h09, 8'h05); tk(1);
        exp_rd(6'h00, 8'h11, "R7 restarted");
        // R8 freeze, running bank continues
        wr(6'h0B, 8'h00); exp_rd(6'h0B, 8'h00, "R8 control cleared");
        tk(5); exp_rd(6'h00, 8'h11, "R8 frozen view");
        wr(6'h0B, 8'h80); exp_rd(6'h00, 8'h11, "R8 no refresh before tick");
        tk(1); exp_rd(6'h00, 8'h17, "R8 caught up");
        // R10 deferred write
        wr(6'h01, 8'h00); wr(6'h02, 8'h10); wr(6'h00, 8'h50);
        wr(6'h0B, 8'h00); wr(6'h02, 8'h30); tk(3);
        exp_rd(6'h00, 8'h50, "R10 frozen hundredths"); exp_rd(6'h02, 8'h30, "R10 visible write");
        wr(6'h0B, 8'h80); tk(1);
        exp_rd(6'h00, 8'h54, "R10 unwritten advanced");
        exp_rd(6'h02, 8'h30, "R10 minutes committed");
        exp_rd(6'h01, 8'h00, "R10 seconds kept");
        tk(1); exp_rd(6'h02, 8'h30, "R10 commit persists");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule